// File: doc/BRIEF.md
# Interrupt Pin Delivery and EOI Engine

This block sits between a bank of interrupt input pins and the fabric that carries interrupt messages to processors. For every pin it keeps a pending bit and, for level-mode pins, a remote-pending lockout bit. It decides when a pin should produce a delivery message and sends that message over a valid/ready handshake. The message carries the pin's vector, destination, destination mode, delivery mode and trigger mode. The per-pin configuration (vector, destination, modes and mask) lives in an external register file and arrives as flat input buses. Remote-pending and pending bits are exposed so that the register file can show them.

Pins report line activity as events. Each event carries the new line level. An edge-mode pin delivers once per assertion, and a repeat assertion while its pending bit is still set is reported as coalesced. A level-mode pin delivers, then locks out until an end-of-interrupt (EOI) notice with a matching vector arrives. The EOI releases the lockout and redelivers if the line is still pending. When one pin keeps being redelivered by back-to-back EOIs, a per-pin counter spots the storm and skips one redelivery. A delay timer then re-services every pending, unlocked level pin when it expires.

Top module: `irq_dispatch_core`

## Requirements
- R1: An event with line level 0 clears that pin's pending bit and never by itself produces a delivery.
- R2: An asserting event on an edge-mode pin (cfg_level bit = 0) whose pending bit is clear sets the pending bit and produces exactly one delivery. An assertion while the pending bit is already set pulses that pin's coal_pulse bit in the same cycle and produces no delivery.
- R3: No delivery is made for a pin whose mask bit is 1, nor for a level-mode pin (cfg_level bit = 1) whose remote-pending bit is set.
- R4: An accepted delivery of a level-mode pin sets its remote-pending bit. A pin configured for edge mode has its remote-pending bit cleared.
- R5: An EOI applies to every level-mode pin whose vector equals the EOI vector. It clears remote-pending and redelivers if the pin is still pending and unmasked. Pins with other vectors are unaffected.
- R6: Each pin counts successive EOI-triggered redeliveries, and the count returns to 0 when an EOI finds the pin masked or not pending. The EOI that would make the count reach STORM_LIMIT skips its redelivery, returns the count to 0 and starts the delay timer.
- R7: DELAY_CYCLES cycles after the timer starts, every level-mode pin that is pending with remote-pending clear is serviced. No such service happens before expiry.
- R8: When a level-mode pin's mask bit goes from 1 to 0 while it is pending with remote-pending clear, the pin is serviced.
- R9: When several pins wait for service, the lowest-numbered pin is delivered first.
- R10: While msg_valid is high and msg_ready low, msg_valid stays high and all message fields hold. The remote-pending update commits only on the cycle when both are high.
- R11: msg_pin, msg_vector, msg_dest, msg_dest_mode, msg_dlv_mode and msg_level equal the delivered pin's number and configuration fields.
- R12: After reset msg_valid is 0 and every pending and remote-pending bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_vector | input | NPINS*VEC_W | Per-pin vector, pin p at bits [p*VEC_W +: VEC_W] |
| cfg_dest | input | NPINS*DEST_W | Per-pin destination ID |
| cfg_dest_mode | input | NPINS | Per-pin destination mode |
| cfg_dlv_mode | input | NPINS*3 | Per-pin delivery mode |
| cfg_level | input | NPINS | Per-pin trigger mode, 1 = level, 0 = edge |
| cfg_mask | input | NPINS | Per-pin mask, 1 = masked |
| line_evt | input | NPINS | Per-pin line event strobe |
| line_lvl | input | NPINS | Line level carried by the event |
| eoi_valid | input | 1 | EOI notice strobe |
| eoi_vector | input | VEC_W | Vector of the EOI notice |
| msg_valid | output | 1 | Delivery message valid |
| msg_ready | input | 1 | Delivery message accepted |
| msg_pin | output | PIN_W | Source pin of the message |
| msg_vector | output | VEC_W | Vector |
| msg_dest | output | DEST_W | Destination ID |
| msg_dest_mode | output | 1 | Destination mode |
| msg_dlv_mode | output | 3 | Delivery mode |
| msg_level | output | 1 | Trigger mode of the message |
| coal_pulse | output | NPINS | One-cycle coalesced-assertion indication |
| pend_irr | output | NPINS | Per-pin pending bits |
| remote_irr | output | NPINS | Per-pin remote-pending bits |

## Verification
The bench builds the block with four pins, STORM_LIMIT of 4 and DELAY_CYCLES of 40. With these values a storm is reached after only four EOIs, and the timer expiry falls inside a short wait that also has a quiet window before it. Four pins are enough for simultaneous requests and a lowest-first ordering check. A random phase of edge assertions and deassertions runs under random ready stalls against a pending-bit model that predicts deliveries and coalesced pulses.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   localparam int DLV_W = 3;
   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;
endpackage

// File: rtl/irqd_pin_slice.sv
module irqd_pin_slice #(
   parameter int STORM_LIMIT = 10000,
   localparam int CNT_W = $clog2(STORM_LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic lvl,
   input  logic level_mode,
   input  logic mask,
   input  logic eoi_hit,
   input  logic take,
   input  logic commit,
   input  logic timer_fire,
   output logic irr,
   output logic remote,
   output logic req,
   output logic eligible,
   output logic coal,
   output logic storm
);
   import irqd_pkg::*;

   logic             irr_q, rem_q, req_q, mask_q;
   logic             irr_d, rem_d, req_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             unmask_rise, idle_level;

   always_comb begin
      coal        = evt & lvl & (trig_e'(level_mode) == TRIG_EDGE) & irr_q;
      unmask_rise = mask_q & ~mask;
      idle_level  = level_mode & irr_q & ~rem_q;
      storm       = 1'b0;
      irr_d       = irr_q;
      rem_d       = rem_q;
      req_d       = req_q & ~take;
      cnt_d       = cnt_q;
      if (evt) begin
         if (!lvl) begin
            irr_d = 1'b0;
         end else if (!coal) begin
            irr_d = 1'b1;
            req_d = 1'b1;
         end
      end
      if (commit && level_mode) rem_d = 1'b1;
      if (unmask_rise && idle_level) req_d = 1'b1;
      if (timer_fire && idle_level) req_d = 1'b1;
      if (eoi_hit && level_mode) begin
         rem_d = 1'b0;
         if (!mask && irr_q) begin
            if (cnt_q == CNT_W'(STORM_LIMIT - 1)) begin
               cnt_d = '0;
               storm = 1'b1;
            end else begin
               cnt_d = cnt_q + 1'b1;
               req_d = 1'b1;
            end
         end else begin
            cnt_d = '0;
         end
      end
      if (trig_e'(level_mode) == TRIG_EDGE) rem_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q  <= 1'b0;
         rem_q  <= 1'b0;
         req_q  <= 1'b0;
         mask_q <= 1'b1;
         cnt_q  <= '0;
      end else begin
         irr_q  <= irr_d;
         rem_q  <= rem_d;
         req_q  <= req_d;
         mask_q <= mask;
         cnt_q  <= cnt_d;
      end
   end

   assign irr      = irr_q;
   assign remote   = rem_q;
   assign req      = req_q;
   assign eligible = req_q & ~mask & (level_mode ? (irr_q & ~rem_q) : 1'b1);
endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
   parameter int N = 24,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      grant = '0;
      idx   = '0;
      any   = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            idx      = IDX_W'(i);
            any      = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irqd_delay_timer.sv
module irqd_delay_timer #(
   parameter int DELAY_CYCLES = 500000,
   localparam int TW = $clog2(DELAY_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic fire,
   output logic running
);
   logic [TW-1:0] cnt_q;
   logic          run_q;

   assign fire    = run_q && (cnt_q == '0);
   assign running = run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else cnt_q <= cnt_q - 1'b1;
      end else if (start) begin
         run_q <= 1'b1;
         cnt_q <= TW'(DELAY_CYCLES - 1);
      end
   end
endmodule

// File: rtl/irq_dispatch_core.sv
module irq_dispatch_core #(
   parameter int NPINS        = 24,
   parameter int VEC_W        = 8,
   parameter int DEST_W       = 8,
   parameter int STORM_LIMIT  = 10000,
   parameter int DELAY_CYCLES = 500000,
   localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1,
   localparam int DLV_W = irqd_pkg::DLV_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPINS*VEC_W-1:0]  cfg_vector,
   input  logic [NPINS*DEST_W-1:0] cfg_dest,
   input  logic [NPINS-1:0]        cfg_dest_mode,
   input  logic [NPINS*DLV_W-1:0]  cfg_dlv_mode,
   input  logic [NPINS-1:0]        cfg_level,
   input  logic [NPINS-1:0]        cfg_mask,
   input  logic [NPINS-1:0]        line_evt,
   input  logic [NPINS-1:0]        line_lvl,
   input  logic                    eoi_valid,
   input  logic [VEC_W-1:0]        eoi_vector,
   output logic                    msg_valid,
   input  logic                    msg_ready,
   output logic [PIN_W-1:0]        msg_pin,
   output logic [VEC_W-1:0]        msg_vector,
   output logic [DEST_W-1:0]       msg_dest,
   output logic                    msg_dest_mode,
   output logic [DLV_W-1:0]        msg_dlv_mode,
   output logic                    msg_level,
   output logic [NPINS-1:0]        coal_pulse,
   output logic [NPINS-1:0]        pend_irr,
   output logic [NPINS-1:0]        remote_irr
);
   if (NPINS < 1 || NPINS > 256) begin : g_bad_npins
      $error("irq_dispatch_core: NPINS out of range");
   end
   if (STORM_LIMIT < 2) begin : g_bad_limit
      $error("irq_dispatch_core: STORM_LIMIT must be at least 2");
   end
   if (DELAY_CYCLES < 1) begin : g_bad_delay
      $error("irq_dispatch_core: DELAY_CYCLES must be positive");
   end

   logic [NPINS-1:0] req_vec, elig_vec, take_vec, commit_vec, storm_vec, hit_vec;
   logic [NPINS-1:0] grant;
   logic [PIN_W-1:0] sel_idx;
   logic             sel_any, capture, accept, timer_fire, timer_run;

   logic             v_q;
   logic [PIN_W-1:0] pin_q;
   logic [VEC_W-1:0] vec_q;
   logic [DEST_W-1:0] dst_q;
   logic             dm_q, lv_q;
   logic [DLV_W-1:0] dlv_q;

   assign accept   = v_q & msg_ready;
   assign take_vec = v_q ? '0 : grant;
   assign capture  = !v_q && sel_any && elig_vec[sel_idx];

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      assign hit_vec[p]    = eoi_valid && (cfg_vector[p*VEC_W +: VEC_W] == eoi_vector);
      assign commit_vec[p] = accept && (pin_q == PIN_W'(p));

      irqd_pin_slice #(.STORM_LIMIT(STORM_LIMIT)) u_slice (
         .clk        (clk),
         .rst_n      (rst_n),
         .evt        (line_evt[p]),
         .lvl        (line_lvl[p]),
         .level_mode (cfg_level[p]),
         .mask       (cfg_mask[p]),
         .eoi_hit    (hit_vec[p]),
         .take       (take_vec[p]),
         .commit     (commit_vec[p]),
         .timer_fire (timer_fire),
         .irr        (pend_irr[p]),
         .remote     (remote_irr[p]),
         .req        (req_vec[p]),
         .eligible   (elig_vec[p]),
         .coal       (coal_pulse[p]),
         .storm      (storm_vec[p])
      );
   end

   irqd_pick #(.N(NPINS)) u_pick (
      .req   (req_vec),
      .grant (grant),
      .idx   (sel_idx),
      .any   (sel_any)
   );

   irqd_delay_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (|storm_vec),
      .fire    (timer_fire),
      .running (timer_run)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         pin_q <= '0;
         vec_q <= '0;
         dst_q <= '0;
         dm_q  <= 1'b0;
         dlv_q <= '0;
         lv_q  <= 1'b0;
      end else if (accept) begin
         v_q <= 1'b0;
      end else if (capture) begin
         v_q   <= 1'b1;
         pin_q <= sel_idx;
         vec_q <= cfg_vector[sel_idx*VEC_W +: VEC_W];
         dst_q <= cfg_dest[sel_idx*DEST_W +: DEST_W];
         dm_q  <= cfg_dest_mode[sel_idx];
         dlv_q <= cfg_dlv_mode[sel_idx*DLV_W +: DLV_W];
         lv_q  <= cfg_level[sel_idx];
      end
   end

   assign msg_valid     = v_q;
   assign msg_pin       = pin_q;
   assign msg_vector    = vec_q;
   assign msg_dest      = dst_q;
   assign msg_dest_mode = dm_q;
   assign msg_dlv_mode  = dlv_q;
   assign msg_level     = lv_q;
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
   parameter int NPINS  = 24,
   parameter int VEC_W  = 8,
   parameter int DEST_W = 8,
   localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NPINS-1:0]  cfg_level,
   input logic [NPINS-1:0]  cfg_mask,
   input logic              eoi_valid,
   input logic              msg_valid,
   input logic              msg_ready,
   input logic [PIN_W-1:0]  msg_pin,
   input logic [VEC_W-1:0]  msg_vector,
   input logic [DEST_W-1:0] msg_dest,
   input logic              msg_level,
   input logic [NPINS-1:0]  coal_pulse,
   input logic [NPINS-1:0]  pend_irr,
   input logic [NPINS-1:0]  remote_irr
);
   logic [NPINS-1:0] mask_prev, rem_prev, lvl_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_prev <= '1;
         rem_prev  <= '0;
         lvl_prev  <= '0;
      end else begin
         mask_prev <= cfg_mask;
         rem_prev  <= remote_irr;
         lvl_prev  <= cfg_level;
      end
   end

   a_r10_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> msg_valid);

   a_r10_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> ($stable(msg_pin) && $stable(msg_vector) && $stable(msg_dest)));

   a_r3_not_masked: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_valid) |-> !mask_prev[msg_pin]);

   a_r3_no_locked_level: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(msg_valid) && msg_level) |-> !rem_prev[msg_pin]);

   a_r4_level_sets_remote: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready && msg_level && cfg_level[msg_pin] && !eoi_valid)
      |=> remote_irr[$past(msg_pin)]);

   a_r4_edge_no_remote: assert property (@(posedge clk) disable iff (!rst_n)
      (remote_irr & ~lvl_prev) == '0);

   a_r2_coal_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (coal_pulse & ~pend_irr) == '0);
endmodule

bind irq_dispatch_core irqd_checker #(
   .NPINS (NPINS),
   .VEC_W (VEC_W),
   .DEST_W(DEST_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_level  (cfg_level),
   .cfg_mask   (cfg_mask),
   .eoi_valid  (eoi_valid),
   .msg_valid  (msg_valid),
   .msg_ready  (msg_ready),
   .msg_pin    (msg_pin),
   .msg_vector (msg_vector),
   .msg_dest   (msg_dest),
   .msg_level  (msg_level),
   .coal_pulse (coal_pulse),
   .pend_irr   (pend_irr),
   .remote_irr (remote_irr)
);

// File: tb/tb_irq_dispatch_core.sv
module tb_irq_dispatch_core;
   localparam int NP    = 4;
   localparam int VW    = 8;
   localparam int DW    = 4;
   localparam int LIM   = 4;
   localparam int DLY   = 40;
   localparam int PW    = 2;
   localparam int DLV_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP*VW-1:0]    cfg_vector;
   logic [NP*DW-1:0]    cfg_dest;
   logic [NP-1:0]       cfg_dest_mode;
   logic [NP*DLV_W-1:0] cfg_dlv_mode;
   logic [NP-1:0]       cfg_level = '0;
   logic [NP-1:0]       cfg_mask = '1;
   logic [NP-1:0]       line_evt = '0;
   logic [NP-1:0]       line_lvl = '0;
   logic                eoi_valid = 1'b0;
   logic [VW-1:0]       eoi_vector = '0;
   logic                msg_valid, msg_ready;
   logic [PW-1:0]       msg_pin;
   logic [VW-1:0]       msg_vector;
   logic [DW-1:0]       msg_dest;
   logic                msg_dest_mode, msg_level;
   logic [DLV_W-1:0]    msg_dlv_mode;
   logic [NP-1:0]       coal_pulse, pend_irr, remote_irr;

   int  total = 0;
   int  bad = 0;
   bit  rnd_ready = 1'b0;
   bit  ready_cmd = 1'b1;
   int  log_n = 0;
   int  log_pin [0:511];
   int  per_pin [NP];
   int  coal_seen [NP];
   int  unstable = 0;
   logic [VW-1:0] last_vec;
   logic [DW-1:0] last_dst;
   logic          last_dm, last_lv;
   logic [DLV_W-1:0] last_dlv;
   logic          prev_stall = 1'b0;
   logic [PW-1:0] prev_pin;
   logic [VW-1:0] prev_vec;

   always #10 clk = ~clk;

   irq_dispatch_core #(
      .NPINS(NP), .VEC_W(VW), .DEST_W(DW),
      .STORM_LIMIT(LIM), .DELAY_CYCLES(DLY)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_vector(cfg_vector), .cfg_dest(cfg_dest), .cfg_dest_mode(cfg_dest_mode),
      .cfg_dlv_mode(cfg_dlv_mode), .cfg_level(cfg_level), .cfg_mask(cfg_mask),
      .line_evt(line_evt), .line_lvl(line_lvl),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_pin(msg_pin),
      .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_dest_mode(msg_dest_mode),
      .msg_dlv_mode(msg_dlv_mode), .msg_level(msg_level),
      .coal_pulse(coal_pulse), .pend_irr(pend_irr), .remote_irr(remote_irr)
   );

   function automatic logic [VW-1:0] vec_of(int p);
      return VW'(8'h20 + p);
   endfunction

   initial begin
      for (int p = 0; p < NP; p++) begin
         cfg_vector[p*VW +: VW]       = vec_of(p);
         cfg_dest[p*DW +: DW]         = DW'(p + 1);
         cfg_dest_mode[p]             = p[0];
         cfg_dlv_mode[p*DLV_W +: DLV_W] = DLV_W'(p);
         per_pin[p] = 0;
         coal_seen[p] = 0;
      end
   end

   always @(posedge clk) begin
      #1;
      msg_ready = rnd_ready ? 1'($urandom_range(0, 1)) : ready_cmd;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall && msg_valid && (msg_pin !== prev_pin || msg_vector !== prev_vec))
            unstable++;
         if (prev_stall && !msg_valid) unstable++;
         prev_stall = msg_valid && !msg_ready;
         prev_pin   = msg_pin;
         prev_vec   = msg_vector;
         for (int p = 0; p < NP; p++) if (coal_pulse[p]) coal_seen[p]++;
         if (msg_valid && msg_ready) begin
            log_pin[log_n % 512] = int'(msg_pin);
            log_n++;
            per_pin[msg_pin]++;
            last_vec = msg_vector;
            last_dst = msg_dest;
            last_dm  = msg_dest_mode;
            last_lv  = msg_level;
            last_dlv = msg_dlv_mode;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic pulse(int p, bit lv);
      @(posedge clk); #2;
      line_evt[p] = 1'b1;
      line_lvl[p] = lv;
      @(posedge clk); #2;
      line_evt = '0;
   endtask

   task automatic eoi(logic [VW-1:0] v);
      @(posedge clk); #2;
      eoi_valid = 1'b1;
      eoi_vector = v;
      @(posedge clk); #2;
      eoi_valid = 1'b0;
   endtask

   task automatic cfg_step(int p, bit lvl, bit msk);
      @(posedge clk); #2;
      cfg_level[p] = lvl;
      cfg_mask[p] = msk;
   endtask

   initial begin
      #(20 * 20000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int base, c0;
      bit m_irr [NP];
      int exp_cnt [NP];
      int exp_coal [NP];
      int exp_tot;
      void'($urandom(32'd4242));
      step(3);
      rst_n = 1'b1;
      step(1);
      // R12 reset state
      chk(msg_valid == 1'b0, "R12 valid", int'(msg_valid), 0);
      chk(pend_irr == '0, "R12 pend", int'(pend_irr), 0);
      chk(remote_irr == '0, "R12 remote", int'(remote_irr), 0);

      // R2 / R11: edge pin 1 unmasked delivers once with its fields
      cfg_step(1, 1'b0, 1'b0);
      base = log_n;
      pulse(1, 1'b1);
      step(6);
      chk(log_n - base == 1, "R2 single delivery", log_n - base, 1);
      chk(last_vec == vec_of(1) && last_dst == DW'(2) && last_dm == 1'b1 &&
          last_dlv == 3'd1 && last_lv == 1'b0 && log_pin[base % 512] == 1,
          "R11 fields", int'(last_vec), int'(vec_of(1)));
      chk(pend_irr[1] == 1'b1, "R2 pending set", int'(pend_irr[1]), 1);
      c0 = coal_seen[1];
      pulse(1, 1'b1);
      step(6);
      chk(coal_seen[1] - c0 == 1, "R2 coal pulse", coal_seen[1] - c0, 1);
      chk(log_n - base == 1, "R2 no redelivery", log_n - base, 1);
      // R1 deassert clears pending, no delivery
      pulse(1, 1'b0);
      step(6);
      chk(pend_irr[1] == 1'b0, "R1 pend cleared", int'(pend_irr[1]), 0);
      chk(log_n - base == 1, "R1 no delivery", log_n - base, 1);

      // R3 masked edge pin 0
      cfg_step(0, 1'b0, 1'b1);
      base = log_n;
      pulse(0, 1'b1);
      step(6);
      chk(log_n == base, "R3 masked edge", log_n - base, 0);
      pulse(0, 1'b0);

      // R1 level pin deasserted while masked, then unmasked: nothing
      cfg_step(3, 1'b1, 1'b1);
      pulse(3, 1'b1);
      pulse(3, 1'b0);
      step(2);
      chk(pend_irr[3] == 1'b0, "R1 level pend cleared", int'(pend_irr[3]), 0);
      cfg_step(3, 1'b1, 1'b0);
      step(6);
      chk(log_n == base, "R1 no delivery after unmask", log_n - base, 0);

      // R8 / R4: level pin 2 pending while masked, then unmask
      cfg_step(2, 1'b1, 1'b1);
      pulse(2, 1'b1);
      step(6);
      chk(log_n == base, "R3 masked level", log_n - base, 0);
      cfg_step(2, 1'b1, 1'b0);
      step(6);
      chk(log_n - base == 1 && log_pin[base % 512] == 2, "R8 unmask service", log_n - base, 1);
      chk(remote_irr[2] == 1'b1, "R4 remote set", int'(remote_irr[2]), 1);
      pulse(2, 1'b1);
      step(6);
      chk(log_n - base == 1, "R3 remote lockout", log_n - base, 1);

      // R5 EOI handling
      eoi(vec_of(1));
      step(6);
      chk(remote_irr[2] == 1'b1 && log_n - base == 1, "R5 other vector", int'(remote_irr[2]), 1);
      eoi(vec_of(2));
      step(6);
      chk(log_n - base == 2, "R5 redelivery", log_n - base, 2);
      chk(remote_irr[2] == 1'b1, "R5 remote after redelivery", int'(remote_irr[2]), 1);
      pulse(2, 1'b0);
      eoi(vec_of(2));
      step(6);
      chk(remote_irr[2] == 1'b0 && log_n - base == 2, "R5 clear not pending", log_n - base, 2);

      // R6 storm and R7 timer
      base = log_n;
      pulse(2, 1'b1);
      step(6);
      chk(log_n - base == 1, "R6 first delivery", log_n - base, 1);
      for (int k = 0; k < LIM - 1; k++) begin
         eoi(vec_of(2));
         step(6);
      end
      chk(log_n - base == LIM, "R6 redeliveries", log_n - base, LIM);
      eoi(vec_of(2));
      step(30);
      chk(log_n - base == LIM && remote_irr[2] == 1'b0, "R6 skipped", log_n - base, LIM);
      step(20);
      chk(log_n - base == LIM + 1, "R7 timer service", log_n - base, LIM + 1);
      chk(remote_irr[2] == 1'b1, "R7 remote after timer", int'(remote_irr[2]), 1);
      cfg_step(2, 1'b0, 1'b0);
      step(2);
      chk(remote_irr[2] == 1'b0, "R4 edge clears remote", int'(remote_irr[2]), 0);
      pulse(2, 1'b0);

      // R9 priority and R10 stall
      cfg_step(0, 1'b0, 1'b0);
      cfg_step(3, 1'b0, 1'b0);
      pulse(3, 1'b0);
      ready_cmd = 1'b0;
      base = log_n;
      @(posedge clk); #2;
      line_evt = 4'b1001;
      line_lvl = 4'b1001;
      @(posedge clk); #2;
      line_evt = '0;
      step(5);
      chk(msg_valid && msg_pin == 2'd0, "R9 lowest held", int'(msg_pin), 0);
      ready_cmd = 1'b1;
      step(8);
      chk(log_n - base == 2 && log_pin[base % 512] == 0 && log_pin[(base + 1) % 512] == 3,
          "R9 order", log_pin[base % 512], 0);
      pulse(0, 1'b0);
      pulse(3, 1'b0);
      cfg_step(1, 1'b1, 1'b0);
      ready_cmd = 1'b0;
      pulse(1, 1'b1);
      step(5);
      chk(msg_valid && remote_irr[1] == 1'b0, "R10 no commit while stalled", int'(remote_irr[1]), 0);
      ready_cmd = 1'b1;
      step(4);
      chk(remote_irr[1] == 1'b1, "R10 commit on handshake", int'(remote_irr[1]), 1);
      pulse(1, 1'b0);
      eoi(vec_of(1));

      // random edge phase with random ready stalls
      for (int p = 0; p < NP; p++) begin
         cfg_step(p, 1'b0, 1'b0);
         pulse(p, 1'b0);
      end
      step(10);
      for (int p = 0; p < NP; p++) begin
         m_irr[p] = 1'b0;
         exp_cnt[p] = per_pin[p];
         exp_coal[p] = coal_seen[p];
      end
      exp_tot = log_n;
      rnd_ready = 1'b1;
      for (int it = 0; it < 300; it++) begin
         int p;
         bit lv;
         p = $urandom_range(0, NP - 1);
         lv = 1'($urandom_range(0, 1));
         if (!lv) m_irr[p] = 1'b0;
         else if (m_irr[p]) exp_coal[p]++;
         else begin
            m_irr[p] = 1'b1;
            exp_cnt[p]++;
            exp_tot++;
         end
         pulse(p, lv);
         for (int w = 0; w < 60 && log_n != exp_tot; w++) step(1);
      end
      rnd_ready = 1'b0;
      ready_cmd = 1'b1;
      step(20);
      for (int p = 0; p < NP; p++) begin
         chk(per_pin[p] == exp_cnt[p], "R2 random deliveries", per_pin[p], exp_cnt[p]);
         chk(coal_seen[p] == exp_coal[p], "R2 random coalesced", coal_seen[p], exp_coal[p]);
      end
      chk(unstable == 0, "R10 stall stability", unstable, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule